// File: doc/BRIEF.md
# Per-Pixel Colour Blend Unit

This block does the last arithmetic step on each main-screen pixel. A pixel has three 5-bit channels (red, green, blue). The block adds a second operand to the pixel or subtracts it, and it can halve the result. The second operand is either the matching subscreen pixel or a programmable fixed colour. A colour-window input drives two controls. One forces the main colour to black. The other stops the blend for the pixel.

Each clock the block takes one main pixel, a code naming the layer it came from, the subscreen pixel, a flag that marks the subscreen pixel as backdrop, and the window signal. One clock later it gives one blended pixel. A byte-wide write port loads the fixed colour. One intensity value can go to any subset of the three channels in a single write. Choosing which layer wins at a pixel is done upstream.

Top module: `colour_blend`

## Requirements
- R1: Pixels are 15 bits: red in bits 4:0, green in 9:5, blue in 14:10. The output register is zero after reset, and each pixel appears on `pix_out` one clock after its inputs are presented.
- R2: In add mode (`sub_op`=0) each channel is the sum of the two operands, limited to 31.
- R3: In subtract mode (`sub_op`=1) each channel is the main channel minus the operand channel, limited to 0. For example, (31,31,0) minus (0,16,16) gives (31,15,0).
- R4: With `half_en`=1, each channel of the add or subtract result is shifted right by one.
- R5: With `sub_sel`=0 the operand is the fixed colour. With `sub_sel`=1 it is `sub_px`. If `sub_bd`=1 in that case, the fixed colour is used instead and no halving is done.
- R6: `clip_mode` picks when the main colour is forced to zero before the arithmetic: 00 never, 01 when `win_in`=0, 10 when `win_in`=1, 11 always.
- R7: `stop_mode` uses the same four codes to pick when blending is suppressed for the pixel.
- R8: Halving is not done on a pixel whose main colour is forced to zero.
- R9: `main_src` codes 0 to 3 are the four background layers, 4 is sprites and 5 is the backdrop. Blending applies only when bit `main_src` of `src_en` is 1. Codes 6 and 7 never blend.
- R10: A write with `fix_we`=1 splits `fix_wdata` into an intensity (bits 4:0) and three channel selects: bit 5 red, bit 6 green, bit 7 blue. The intensity is stored in each selected channel. Unselected channels keep their value, and a write with no select bit set changes nothing. The fixed colour is zero after reset.
- R11: When a pixel is not blended, the output is the main colour, after forcing to zero if that applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fix_we | input | 1 | Fixed-colour write strobe |
| fix_wdata | input | 8 | Channel selects (7:5) and intensity (4:0) |
| clip_mode | input | 2 | Window region for forcing the main colour to zero |
| stop_mode | input | 2 | Window region for suppressing the blend |
| sub_sel | input | 1 | 1: subscreen pixel is the operand, 0: fixed colour |
| sub_op | input | 1 | 1: subtract, 0: add |
| half_en | input | 1 | Halve the blend result |
| src_en | input | 6 | Blend enable for each main source code |
| main_px | input | 15 | Main-screen pixel |
| main_src | input | 3 | Source layer code of the main pixel |
| sub_px | input | 15 | Subscreen pixel |
| sub_bd | input | 1 | Subscreen pixel is backdrop |
| win_in | input | 1 | Pixel lies inside the colour window |
| pix_out | output | 15 | Final colour, one clock after the inputs |

## Verification
The bench aims at saturation on each channel taken separately. A design that wraps an overflowing sum gives dark channels, and a design that borrows across channels breaks the subtract example. It checks the backdrop substitution together with halving; a design that still halves there gives half the fixed colour. It runs all four window codes for both the clip control and the stop control, so swapping the inside and outside cases shows as a wrong colour. It also checks that halving is skipped on clipped pixels and that a fixed-colour write only changes the channels it selects, including a write that selects no channel.

// File: rtl/colour_blend.sv
module colour_blend #(
  parameter int CW   = 5,
  parameter int NSRC = 6,
  localparam int PW   = 3 * CW,
  localparam int FW   = CW + 3,
  localparam int SRCW = $clog2(NSRC + 1),
  localparam int NEXT = 2 ** SRCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fix_we,
  input  logic [FW-1:0]   fix_wdata,
  input  logic [1:0]      clip_mode,
  input  logic [1:0]      stop_mode,
  input  logic            sub_sel,
  input  logic            sub_op,
  input  logic            half_en,
  input  logic [NSRC-1:0] src_en,
  input  logic [PW-1:0]   main_px,
  input  logic [SRCW-1:0] main_src,
  input  logic [PW-1:0]   sub_px,
  input  logic            sub_bd,
  input  logic            win_in,
  output logic [PW-1:0]   pix_out
);

  function automatic logic region_hit(input logic [1:0] mode, input logic win);
    case (mode)
      2'b00:   region_hit = 1'b0;
      2'b01:   region_hit = !win;
      2'b10:   region_hit = win;
      default: region_hit = 1'b1;
    endcase
  endfunction

  logic [PW-1:0]   fixed_q;
  logic [PW-1:0]   mixed;
  logic [NEXT-1:0] en_ext;

  wire clip    = region_hit(clip_mode, win_in);
  wire stop    = region_hit(stop_mode, win_in);
  wire use_fix = !sub_sel || sub_bd;

  assign en_ext = {{(NEXT - NSRC){1'b0}}, src_en};

  wire           blend   = en_ext[main_src] && !stop;
  wire           do_half = half_en && !clip && !(sub_sel && sub_bd);
  wire [PW-1:0]  base    = clip ? '0 : main_px;
  wire [PW-1:0]  opnd    = use_fix ? fixed_q : sub_px;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    wire [CW-1:0] a   = base[c*CW +: CW];
    wire [CW-1:0] b   = opnd[c*CW +: CW];
    wire [CW:0]   sum = {1'b0, a} + {1'b0, b};
    wire [CW-1:0] dif = (a >= b) ? (a - b) : '0;
    logic [CW-1:0] res;

    always_comb begin
      if (!sub_op)
        res = do_half ? sum[CW:1] : (sum[CW] ? {CW{1'b1}} : sum[CW-1:0]);
      else
        res = do_half ? {1'b0, dif[CW-1:1]} : dif;
    end

    assign mixed[c*CW +: CW] = blend ? res : a;

    always_ff @(posedge clk) begin
      if (!rst_n)
        fixed_q[c*CW +: CW] <= '0;
      else if (fix_we && fix_wdata[CW + c])
        fixed_q[c*CW +: CW] <= fix_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= mixed;
  end

endmodule

module colour_blend_chk #(
  parameter int CW   = 5,
  parameter int NSRC = 6,
  localparam int PW   = 3 * CW,
  localparam int FW   = CW + 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fix_we,
  input logic [1:0]    clip_mode,
  input logic [1:0]    stop_mode,
  input logic          sub_op,
  input logic          half_en,
  input logic [PW-1:0] main_px,
  input logic [PW-1:0] pix_out,
  input logic [PW-1:0] fixed_q
);

  assert_clip_and_stop_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_mode == 2'b11 && stop_mode == 2'b11) |=> pix_out == '0);

  assert_stop_passes_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode == 2'b11 && clip_mode == 2'b00) |=> pix_out == $past(main_px));

  assert_fixed_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_we |=> $stable(fixed_q));

  assert_add_no_decrease_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_mode == 2'b00 && !sub_op && !half_en) |=>
      (pix_out[CW-1:0] >= $past(main_px[CW-1:0])) &&
      (pix_out[2*CW-1:CW] >= $past(main_px[2*CW-1:CW])) &&
      (pix_out[PW-1:2*CW] >= $past(main_px[PW-1:2*CW])));

  assert_sub_no_increase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_mode == 2'b00 && sub_op) |=>
      (pix_out[CW-1:0] <= $past(main_px[CW-1:0])) &&
      (pix_out[2*CW-1:CW] <= $past(main_px[2*CW-1:CW])) &&
      (pix_out[PW-1:2*CW] <= $past(main_px[PW-1:2*CW])));

endmodule

bind colour_blend colour_blend_chk #(.CW(CW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fix_we(fix_we), .clip_mode(clip_mode),
  .stop_mode(stop_mode), .sub_op(sub_op), .half_en(half_en),
  .main_px(main_px), .pix_out(pix_out), .fixed_q(fixed_q)
);

// File: tb/tb_colour_blend.sv
module tb_colour_blend;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fix_we;
  logic [7:0]  fix_wdata;
  logic [1:0]  clip_mode, stop_mode;
  logic        sub_sel, sub_op, half_en;
  logic [5:0]  src_en;
  logic [14:0] main_px, sub_px;
  logic [2:0]  main_src;
  logic        sub_bd, win_in;
  logic [14:0] pix_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  colour_blend dut (
    .clk(clk), .rst_n(rst_n), .fix_we(fix_we), .fix_wdata(fix_wdata),
    .clip_mode(clip_mode), .stop_mode(stop_mode), .sub_sel(sub_sel),
    .sub_op(sub_op), .half_en(half_en), .src_en(src_en), .main_px(main_px),
    .main_src(main_src), .sub_px(sub_px), .sub_bd(sub_bd), .win_in(win_in),
    .pix_out(pix_out)
  );

  function automatic logic [14:0] px(input int r, input int g, input int b);
    px = {b[4:0], g[4:0], r[4:0]};
  endfunction

  typedef struct packed {
    logic [1:0]  clip;
    logic [1:0]  stp;
    logic        usb;
    logic        sop;
    logic        hlf;
    logic [5:0]  en;
    logic [2:0]  src;
    logic [14:0] mp;
    logic [14:0] sp;
    logic        bd;
    logic        win;
    logic [14:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [5:0] ALL = 6'h3F;
  localparam int NV = 20;
  // fixed colour during the table: r=10 g=20 b=5
  localparam vec_t VT [NV] = '{
    '{2'b00, 2'b00, 1'b1, 1'b0, 1'b0, ALL, 3'd0, px(20,5,30), px(15,3,1), 1'b0, 1'b0, px(31,8,31), 4'd2},   // R2
    '{2'b00, 2'b00, 1'b1, 1'b1, 1'b0, ALL, 3'd1, px(31,31,0), px(0,16,16), 1'b0, 1'b0, px(31,15,0), 4'd3},  // R3
    '{2'b00, 2'b00, 1'b1, 1'b0, 1'b1, ALL, 3'd2, px(20,5,30), px(15,3,1), 1'b0, 1'b0, px(17,4,15), 4'd4},   // R4
    '{2'b00, 2'b00, 1'b1, 1'b1, 1'b1, ALL, 3'd3, px(31,31,0), px(0,16,16), 1'b0, 1'b0, px(15,7,0), 4'd4},   // R4
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, ALL, 3'd4, px(1,2,3), px(31,31,31), 1'b0, 1'b0, px(11,22,8), 4'd5},   // R5
    '{2'b00, 2'b00, 1'b1, 1'b0, 1'b1, ALL, 3'd0, px(4,4,4), px(31,31,31), 1'b1, 1'b0, px(14,24,9), 4'd5},   // R5
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 6'b111110, 3'd0, px(7,8,9), px(0,0,0), 1'b0, 1'b0, px(7,8,9), 4'd9}, // R9
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, ALL, 3'd6, px(7,8,9), px(0,0,0), 1'b0, 1'b0, px(7,8,9), 4'd9},       // R9
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 6'b100000, 3'd5, px(0,0,0), px(0,0,0), 1'b0, 1'b0, px(10,20,5), 4'd9}, // R9
    '{2'b11, 2'b00, 1'b0, 1'b0, 1'b1, ALL, 3'd0, px(30,30,30), px(0,0,0), 1'b0, 1'b0, px(10,20,5), 4'd8},  // R8
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b1, ALL, 3'd0, px(2,2,2), px(0,0,0), 1'b0, 1'b1, px(6,11,3), 4'd6},      // R6
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(2,2,2), px(0,0,0), 1'b0, 1'b0, px(10,20,5), 4'd6},     // R6
    '{2'b10, 2'b00, 1'b0, 1'b1, 1'b0, ALL, 3'd0, px(20,20,20), px(0,0,0), 1'b0, 1'b1, px(0,0,0), 4'd6},    // R6
    '{2'b00, 2'b11, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(9,9,9), px(0,0,0), 1'b0, 1'b0, px(9,9,9), 4'd7},       // R7
    '{2'b00, 2'b10, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(9,9,9), px(0,0,0), 1'b0, 1'b0, px(19,29,14), 4'd7},    // R7
    '{2'b00, 2'b10, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(9,9,9), px(0,0,0), 1'b0, 1'b1, px(9,9,9), 4'd7},       // R7
    '{2'b11, 2'b11, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(9,9,9), px(0,0,0), 1'b0, 1'b0, px(0,0,0), 4'd11},      // R11
    '{2'b00, 2'b01, 1'b0, 1'b0, 1'b0, ALL, 3'd0, px(3,3,3), px(0,0,0), 1'b0, 1'b0, px(3,3,3), 4'd7},       // R7
    '{2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 6'b000000, 3'd0, px(9,9,9), px(0,0,0), 1'b0, 1'b0, px(0,0,0), 4'd11}, // R11
    '{2'b00, 2'b00, 1'b0, 1'b1, 1'b0, ALL, 3'd0, px(5,30,5), px(0,0,0), 1'b0, 1'b0, px(0,10,0), 4'd3}      // R3
  };

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic defaults();
    fix_we = 1'b0; fix_wdata = 8'h00;
    clip_mode = 2'b00; stop_mode = 2'b00;
    sub_sel = 1'b0; sub_op = 1'b0; half_en = 1'b0;
    src_en = ALL; main_src = 3'd0;
    main_px = '0; sub_px = '0; sub_bd = 1'b0; win_in = 1'b0;
  endtask

  task automatic fixed_write(input logic [7:0] d);
    @(negedge clk);
    fix_we = 1'b1; fix_wdata = d;
    @(negedge clk);
    fix_we = 1'b0;
  endtask

  // add fixed colour to black main pixel: output shows the fixed colour
  task automatic read_fixed(input string req, input logic [14:0] exp);
    clip_mode = 2'b00; stop_mode = 2'b00; sub_sel = 1'b0; sub_op = 1'b0;
    half_en = 1'b0; src_en = ALL; main_src = 3'd0; main_px = '0;
    @(negedge clk);
    check(req, pix_out, exp);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    defaults();
    main_px = px(31,31,31);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset output", pix_out, '0);
    rst_n = 1'b1;
    defaults();

    // R10: fixed colour zero after reset, then per-channel writes
    read_fixed("R10 reset fixed", px(0,0,0));
    fixed_write(8'hE7);
    read_fixed("R10 all channels", px(7,7,7));
    fixed_write(8'h3F);
    read_fixed("R10 red only", px(31,7,7));
    fixed_write(8'h0F);
    read_fixed("R10 no select ignored", px(31,7,7));
    fixed_write(8'h20 | 8'd10);
    fixed_write(8'h40 | 8'd20);
    fixed_write(8'h80 | 8'd5);
    read_fixed("R10 table colour", px(10,20,5));

    for (int i = 0; i < NV; i++) begin
      clip_mode = VT[i].clip; stop_mode = VT[i].stp;
      sub_sel = VT[i].usb; sub_op = VT[i].sop; half_en = VT[i].hlf;
      src_en = VT[i].en; main_src = VT[i].src;
      main_px = VT[i].mp; sub_px = VT[i].sp; sub_bd = VT[i].bd; win_in = VT[i].win;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VT[i].req, i), pix_out, VT[i].exp);
    end

    // R1 latency: new input is not visible before the next rising edge
    defaults();
    src_en = 6'b0;
    main_px = px(1,2,3);
    @(negedge clk);
    check("R1 first pixel", pix_out, px(1,2,3));
    main_px = px(4,5,6);
    #1;
    check("R1 held before edge", pix_out, px(1,2,3));
    @(negedge clk);
    check("R1 one clock later", pix_out, px(4,5,6));

    // R2 saturation on all channels at once
    defaults();
    sub_sel = 1'b1; main_px = px(31,16,17); sub_px = px(31,16,14);
    @(negedge clk);
    check("R2 saturate", pix_out, px(31,31,31));

    // R3 subtract all to floor
    sub_op = 1'b1; main_px = px(0,1,2); sub_px = px(31,31,31);
    @(negedge clk);
    check("R3 floor", pix_out, px(0,0,0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule